// File: doc/BRIEF.md
# Memory-Mapped Function Request Controller

This block is the command and status register interface of a processor that carries out functions for an attached controller. The controller reaches it through a control window whose mapping is fixed: a small bank of word registers holding a process index, two operands, an opcode, a return value, a status word and an interrupt control bit. Software loads the index and the operands, then writes the opcode. That write launches the request.

Requests run strictly one at a time. While a request runs, the status word reports busy. One cycle later the function completes: the return value is written, the status shows either a successful or a faulted completion, and an interrupt pulse is raised. The failure interrupt cannot be masked. The success interrupt can be switched off, so that software hears only about failures.

Three functions are provided: a no-operation, an add that returns a result, and a remap stub that moves the base address of one data window and returns the base it held before. The control window itself can never be remapped. Any other opcode, and any process index out of range, completes as a fault.

Top module: `fnreq_ctrl`

## Requirements
- R1: After reset the status word (address 0) reads 0: completion state 00 and overrun bit 2 clear. The return value (address 6) reads 0, the interrupt control (address 1) reads 1, and neither interrupt output is high.
- R2: A write to the opcode register (address 5) while the completion state is not busy is accepted. The completion state reads 01 (busy) in the cycle after the write edge and reads 10 (done-ok) or 11 (done-fault) from the following edge on.
- R3: A write to the opcode register while the state is busy does not change the request in flight. It sets the sticky overrun flag, status bit 2, which stays set until the next request is accepted.
- R4: Opcode 1 (add) completes done-ok with return value operand0 (address 3) plus operand1 (address 4), modulo 2^16.
- R5: An opcode other than 0, 1 or 2 completes done-fault with return value 0, one cycle after dispatch.
- R6: Opcode 2 (remap) takes the window number from operand0 bits [2:0] and the new base from operand1. For windows 0 to 3 it completes done-ok and returns the base that window held before, which is 0 after reset. In the completion cycle it pulses map_we, with map_idx and map_base_o giving the window number and the new base.
- R7: A remap aimed at the control window (window 4), or at a window number of 5 or more, completes done-fault with return value 0 and does not pulse map_we.
- R8: A process index (address 2) of 4 or more makes any opcode complete done-fault with return value 0.
- R9: Every done-fault completion raises irq_fault for exactly one cycle, whatever the interrupt control holds.
- R10: A done-ok completion raises irq_ok for one cycle only when interrupt control bit 0 is 1. When the bit is 0, irq_ok stays low.
- R11: Writes to the process index and operand registers while the state is busy are ignored. Those registers read back their earlier values.
- R12: Opcode 0 (no-operation) completes done-ok with return value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq_ok | output | 1 | One-cycle pulse on successful completion, maskable |
| irq_fault | output | 1 | One-cycle pulse on faulted completion |
| map_we | output | 1 | One-cycle pulse when the remap stub updates a window |
| map_idx | output | 3 | Window number being remapped |
| map_base_o | output | 16 | New base for that window |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- A second opcode written during the busy cycle. A design that accepts it would finish with the wrong function's result or status. A design that drops the sticky flag would hide the overrun from software.
- Remap requests aimed at the control window and at window numbers past the last window. A design that misses either case would pulse map_we and report success on a window that must stay fixed or does not exist.
- Success interrupts with the mask cleared while failures still interrupt. A design that gates both interrupts with the mask would leave software deaf to faults.
- An add that wraps past 16 bits, a remap that must return the previously stored base, and a process index just past the limit. These catch results computed to the wrong width, a missing base store, and an off-by-one in the index check.

// File: rtl/fnreq_ctrl.sv
module fnreq_ctrl #(
  parameter int DATA_W   = 16,
  parameter int NWIN     = 5,
  parameter int CTRL_WIN = 4,
  parameter int NPROC    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [2:0]                 bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq_ok,
  output logic                       irq_fault,
  output logic                       map_we,
  output logic [$clog2(NWIN)-1:0]    map_idx,
  output logic [DATA_W-1:0]          map_base_o
);
  localparam int WIN_W = $clog2(NWIN);
  localparam logic [1:0] ST_IDLE = 2'b00, ST_BUSY = 2'b01, ST_OK = 2'b10, ST_FAULT = 2'b11;
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_PIDX = 3'd2, A_OP0 = 3'd3,
                         A_OP1 = 3'd4, A_OPC = 3'd5, A_RET = 3'd6;

  logic [1:0]        state;
  logic              ovr, irq_en;
  logic [DATA_W-1:0] pidx_q, op0_q, op1_q, opc_q, ret_q;
  logic [DATA_W-1:0] map_base [NWIN];

  logic              wr, busy, wr_opc;
  logic [WIN_W-1:0]  win;
  logic              win_ok, pidx_ok, fault, do_map;
  logic [DATA_W-1:0] res;

  assign wr      = bus_sel && bus_we;
  assign busy    = (state == ST_BUSY);
  assign wr_opc  = wr && (bus_addr == A_OPC);
  assign win     = op0_q[WIN_W-1:0];
  assign win_ok  = (32'(win) < NWIN) && (32'(win) != CTRL_WIN);
  assign pidx_ok = 32'(pidx_q) < NPROC;

  always_comb begin
    res    = '0;
    fault  = 1'b0;
    do_map = 1'b0;
    case (opc_q)
      16'd0: res = '0;
      16'd1: res = op0_q + op1_q;
      16'd2: if (win_ok) begin
               res    = map_base[win];
               do_map = 1'b1;
             end else fault = 1'b1;
      default: fault = 1'b1;
    endcase
    if (!pidx_ok) fault = 1'b1;
    if (fault) begin
      res    = '0;
      do_map = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ovr        <= 1'b0;
      irq_en     <= 1'b1;
      pidx_q     <= '0;
      op0_q      <= '0;
      op1_q      <= '0;
      opc_q      <= '0;
      ret_q      <= '0;
      irq_ok     <= 1'b0;
      irq_fault  <= 1'b0;
      map_we     <= 1'b0;
      map_idx    <= '0;
      map_base_o <= '0;
      for (int i = 0; i < NWIN; i++) map_base[i] <= '0;
    end else begin
      irq_ok    <= 1'b0;
      irq_fault <= 1'b0;
      map_we    <= 1'b0;
      if (wr && bus_addr == A_CTRL) irq_en <= bus_wdata[0];
      if (wr && !busy) begin
        if (bus_addr == A_PIDX) pidx_q <= bus_wdata;
        if (bus_addr == A_OP0)  op0_q  <= bus_wdata;
        if (bus_addr == A_OP1)  op1_q  <= bus_wdata;
      end
      if (wr_opc) begin
        if (busy) ovr <= 1'b1;
        else begin
          ovr   <= 1'b0;
          opc_q <= bus_wdata;
          state <= ST_BUSY;
        end
      end
      if (busy) begin
        state     <= fault ? ST_FAULT : ST_OK;
        ret_q     <= res;
        irq_ok    <= !fault && irq_en;
        irq_fault <= fault;
        map_we    <= do_map;
        if (do_map) begin
          map_idx    <= win;
          map_base_o <= op1_q;
          map_base[win] <= op1_q;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {{(DATA_W-3){1'b0}}, ovr, state};
      A_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, irq_en};
      A_PIDX:  bus_rdata = pidx_q;
      A_OP0:   bus_rdata = op0_q;
      A_OP1:   bus_rdata = op1_q;
      A_OPC:   bus_rdata = opc_q;
      A_RET:   bus_rdata = ret_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module fnreq_ctrl_chk #(
  parameter int NWIN     = 5,
  parameter int CTRL_WIN = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              state,
  input logic                    bus_sel,
  input logic                    bus_we,
  input logic [2:0]              bus_addr,
  input logic                    irq_ok,
  input logic                    irq_fault,
  input logic                    map_we,
  input logic [$clog2(NWIN)-1:0] map_idx
);
  // R2
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'b01 |=> state != 2'b01);
  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01 && $past(state) != 2'b01) |-> $past(bus_sel && bus_we && bus_addr == 3'd5));
  // R9
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'b01 && state == 2'b11) |-> irq_fault);
  // R10
  ok_irq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ok |-> state == 2'b10);
  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ok && irq_fault));
  // R7
  map_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> (32'(map_idx) != CTRL_WIN && 32'(map_idx) < NWIN && state == 2'b10));
endmodule

bind fnreq_ctrl fnreq_ctrl_chk #(.NWIN(NWIN), .CTRL_WIN(CTRL_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .irq_ok(irq_ok), .irq_fault(irq_fault),
  .map_we(map_we), .map_idx(map_idx));

// File: tb/sim_fnreq_ctrl.sv
module sim_fnreq_ctrl;
  localparam int PERIOD = 10;
  localparam int NV = 12;
  // fields: pidx[69:66] op0[65:50] op1[49:34] opc[33:18] state[17:16] ret[15:0]
  localparam logic [69:0] VEC [NV] = '{
    {4'd0, 16'd0,      16'd0,      16'd0, 2'b10, 16'd0},      // R12 nop
    {4'd0, 16'd3,      16'd4,      16'd1, 2'b10, 16'd7},      // R4 add
    {4'd1, 16'hFFFF,   16'd2,      16'd1, 2'b10, 16'd1},      // R4 wrap
    {4'd0, 16'd1,      16'd1,      16'd7, 2'b11, 16'd0},      // R5
    {4'd2, 16'd1,      16'd1,      16'd3, 2'b11, 16'd0},      // R5
    {4'd0, 16'd1,      16'h1234,   16'd2, 2'b10, 16'd0},      // R6 first remap
    {4'd0, 16'd1,      16'h5678,   16'd2, 2'b10, 16'h1234},   // R6 old base
    {4'd0, 16'd4,      16'h9999,   16'd2, 2'b11, 16'd0},      // R7 control window
    {4'd0, 16'd6,      16'h9999,   16'd2, 2'b11, 16'd0},      // R7 no such window
    {4'd3, 16'd1,      16'd1,      16'd1, 2'b10, 16'd2},      // R8 last legal index
    {4'd4, 16'd1,      16'd1,      16'd1, 2'b11, 16'd0},      // R8 index too big
    {4'd0, 16'd0,      16'hAAAA,   16'd2, 2'b10, 16'd0}       // R6 window 0
  };

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, map_base_o;
  logic irq_ok, irq_fault, map_we;
  logic [2:0] map_idx;
  int checks = 0, fails = 0;

  fnreq_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ok(irq_ok), .irq_fault(irq_fault), .map_we(map_we),
    .map_idx(map_idx), .map_base_o(map_base_o));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic load(input logic [15:0] p, input logic [15:0] a, input logic [15:0] b);
    wr(3'd2, p); wr(3'd3, a); wr(3'd4, b);
  endtask

  initial begin
    #(PERIOD*200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [69:0] v;
    #(PERIOD*2 + PERIOD/2);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d); chk("R1 status", d, 16'h0);
    rd(3'd6, d); chk("R1 retval", d, 16'h0);
    rd(3'd1, d); chk("R1 irq ctrl", d, 16'h1);
    chk("R1 irqs", {irq_ok, irq_fault}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      load({12'd0, v[69:66]}, v[65:50], v[49:34]);
      wr(3'd5, v[33:18]);
      rd(3'd0, d); chk("R2 busy", d[1:0], 2'b01);
      @(negedge clk);
      rd(3'd0, d); chk("R2 R5 R7 R8 done state", d[1:0], v[17:16]);
      rd(3'd6, d); chk("R4 R6 R12 retval", d, v[15:0]);
      chk("R9 irq_fault", irq_fault, v[17:16] == 2'b11);
      chk("R10 irq_ok", irq_ok, v[17:16] == 2'b10);
      chk("R6 R7 map_we", map_we, v[33:18] == 16'd2 && v[17:16] == 2'b10);
      if (v[33:18] == 16'd2 && v[17:16] == 2'b10) begin
        chk("R6 map_idx", map_idx, v[52:50]);
        chk("R6 map_base", map_base_o, v[49:34]);
      end
      @(negedge clk);
      chk("R9 R10 pulse width", {irq_ok, irq_fault, map_we}, 3'b000);
    end

    // R3 overrun
    load(16'd0, 16'd5, 16'd6);
    wr(3'd5, 16'd1);
    wr(3'd5, 16'd7);
    rd(3'd0, d); chk("R3 first request kept, overrun set", d[2:0], 3'b110);
    rd(3'd6, d); chk("R3 retval", d, 16'd11);
    @(negedge clk);
    wr(3'd5, 16'd0);
    rd(3'd0, d); chk("R3 overrun cleared on accept", d[2:0], 3'b001);
    @(negedge clk);

    // R11 operand write while busy
    load(16'd0, 16'd1, 16'd1);
    wr(3'd5, 16'd1);
    wr(3'd3, 16'd9);
    rd(3'd6, d); chk("R11 retval", d, 16'd2);
    rd(3'd3, d); chk("R11 operand0 kept", d, 16'd1);
    wr(3'd5, 16'd0);
    wr(3'd2, 16'd7);
    rd(3'd2, d); chk("R11 index kept", d, 16'd0);
    @(negedge clk);

    // R10 masked success, R9 unmaskable failure
    wr(3'd1, 16'd0);
    wr(3'd5, 16'd1);
    chk("R10 no irq while busy", irq_ok, 1'b0);
    @(negedge clk);
    rd(3'd0, d); chk("R10 state ok", d[1:0], 2'b10);
    chk("R10 masked irq_ok", irq_ok, 1'b0);
    wr(3'd5, 16'd9);
    @(negedge clk);
    chk("R9 fault irq when masked", irq_fault, 1'b1);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule